// File: doc/BRIEF.md
# Message Time Tag Counter

This block keeps a 16-bit relative time value used to stamp bus messages as they are handled. A prescaler counts strobes from a 1 µs timebase and advances the count once per selected interval. The interval is a power of two from 2 µs to 64 µs. The counter runs freely and wraps from its all-ones value to zero. When the interrupt option is enabled, that wrap raises a single-cycle pulse.

Synchronize mode commands are decoded elsewhere and arrive here as strobes. A synchronize command without data can zero the count. A synchronize command with data can load the count from the received word. The load can also be restricted to data words whose least significant bit is 0. Each of these actions is enabled by its own option bit.

Top module: `ttag_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `timeTag` reads 0 and `rollIrq` is low.
- R2: For a select code k from 0 to 5, the count advances by exactly one after every 2^(k+1) cycles that have `usTick` high. Examples: code 000 gives 2 µs per step and code 101 gives 64 µs per step. The spacing between `usTick` strobes does not matter.
- R3: Select codes 110 and 111 behave like code 101, so the count advances once every 64 strobes.
- R4: When `rollIrqEn` is 1, an increment from 16'hFFFF to 16'h0000 makes `rollIrq` high for exactly one cycle. That cycle is the same cycle in which `timeTag` first reads 0.
- R5: When `rollIrqEn` is 0, the count still wraps to 0, but `rollIrq` stays low.
- R6: A `syncNoData` strobe with `clrOnSyncEn` = 1 sets the count to 0. With `clrOnSyncEn` = 0, the strobe has no effect on the count.
- R7: A `syncWithData` strobe with `loadOnSyncEn` = 1 loads `syncData` into the count. With `loadOnSyncEn` = 0, the strobe has no effect.
- R8: When `loadLsbFiltEn` = 1, a load takes place only if `syncData[0]` = 0. A strobe carrying an odd data word leaves the count unchanged.
- R9: A clear or a load restarts the prescaler phase and overrides an increment due in the same cycle. If both a clear and a load are enabled in the same cycle, the clear wins.
- R10: A change of `resSel` restarts the prescaler phase and suppresses any increment in that cycle. The count value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usTick | input | 1 | One-cycle strobe from the 1 µs timebase |
| resSel | input | 3 | Resolution select, 000 = 2 µs up to 101 = 64 µs |
| rollIrqEn | input | 1 | Enables the rollover pulse |
| clrOnSyncEn | input | 1 | Enables clearing on synchronize without data |
| loadOnSyncEn | input | 1 | Enables loading on synchronize with data |
| loadLsbFiltEn | input | 1 | Restricts loads to data words with bit 0 equal to 0 |
| syncNoData | input | 1 | Strobe: synchronize command without data received |
| syncWithData | input | 1 | Strobe: synchronize command with data received |
| syncData | input | 16 | Data word carried by the synchronize-with-data command |
| timeTag | output | 16 | Current time tag value |
| rollIrq | output | 1 | Single-cycle rollover interrupt pulse |

## Verification
Each effect depends on the inputs present at one rising edge: an increment, a clear, a load, a phase restart or a wrap. The effect shows on `timeTag` and `rollIrq` right after that edge, so every result is due one cycle after its stimulus. The bench drives inputs on falling edges. A behavioural model updates at each rising edge, and the outputs are compared against it on the next falling edge, exactly one cycle after each stimulus. Every cycle is compared this way, including the cycles in which a strobe should have no effect.

// File: rtl/ttag_pkg.sv
package ttag_pkg;
  // Strobes issued by the control half to the datapath half
  typedef struct packed {
    logic clr;   // zero the count
    logic load;  // take the sync data word
    logic inc;   // one resolution interval has elapsed
  } tagStrobes_t;
endpackage

// File: rtl/ttag_ctrl.sv
module ttag_ctrl
  import ttag_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int MAX_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usTick,
  input  logic [SEL_W-1:0] resSel,
  input  logic             clrOnSyncEn,
  input  logic             loadOnSyncEn,
  input  logic             loadLsbFiltEn,
  input  logic             syncNoData,
  input  logic             syncWithData,
  input  logic             syncLsb,
  output tagStrobes_t      strb
);
  localparam int PRESC_W = MAX_CODE + 1;
  localparam int NCODES  = MAX_CODE + 1;

  logic [PRESC_W-1:0] lastTab [NCODES];
  logic [SEL_W-1:0]   selEff;
  logic [SEL_W-1:0]   resSelQ;
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] lastCount;
  logic               selChg;
  logic               prescRst;
  logic               wantClr;
  logic               wantLoad;

  // terminal prescaler value per resolution code
  for (genvar g = 0; g < NCODES; g++) begin : g_last
    assign lastTab[g] = PRESC_W'((2 ** (g + 1)) - 1);
  end

  always_comb begin
    selEff = (resSel > SEL_W'(MAX_CODE)) ? SEL_W'(MAX_CODE) : resSel;
    lastCount = lastTab[selEff];
  end

  assign selChg   = (resSel != resSelQ);
  assign wantClr  = syncNoData & clrOnSyncEn;
  assign wantLoad = syncWithData & loadOnSyncEn & ~(loadLsbFiltEn & syncLsb);
  assign prescRst = wantClr | wantLoad | selChg;

  always_comb begin
    strb.clr  = wantClr;
    strb.load = wantLoad & ~wantClr;
    strb.inc  = usTick & (presc == lastCount) & ~prescRst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      resSelQ <= '0;
    end else begin
      resSelQ <= resSel;
      if (prescRst)
        presc <= '0;
      else if (usTick)
        presc <= (presc == lastCount) ? '0 : presc + 1'b1;
    end
  end

  AST_INC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    strb.inc |=> !strb.inc); // R2
  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    presc <= lastCount || selChg); // R10
endmodule

// File: rtl/ttag_dp.sv
module ttag_dp
  import ttag_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tagStrobes_t      strb,
  input  logic [TAG_W-1:0] syncData,
  input  logic             rollIrqEn,
  output logic [TAG_W-1:0] timeTag,
  output logic             rollIrq
);
  logic atTop;
  assign atTop = &timeTag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeTag <= '0;
      rollIrq <= 1'b0;
    end else begin
      rollIrq <= strb.inc & ~strb.clr & ~strb.load & atTop & rollIrqEn;
      if (strb.clr)
        timeTag <= '0;
      else if (strb.load)
        timeTag <= syncData;
      else if (strb.inc)
        timeTag <= timeTag + 1'b1;
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> timeTag == '0); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> timeTag == $past(syncData)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.clr || strb.load || strb.inc) |=> $stable(timeTag)); // R10
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rollIrq |-> timeTag == '0); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rollIrq |-> $past(rollIrqEn)); // R5
endmodule

// File: rtl/ttag_counter.sv
module ttag_counter
  import ttag_pkg::*;
#(
  parameter int TAG_W    = 16,
  parameter int SEL_W    = 3,
  parameter int MAX_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usTick,
  input  logic [SEL_W-1:0] resSel,
  input  logic             rollIrqEn,
  input  logic             clrOnSyncEn,
  input  logic             loadOnSyncEn,
  input  logic             loadLsbFiltEn,
  input  logic             syncNoData,
  input  logic             syncWithData,
  input  logic [TAG_W-1:0] syncData,
  output logic [TAG_W-1:0] timeTag,
  output logic             rollIrq
);
  tagStrobes_t strb;

  ttag_ctrl #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .resSel(resSel),
    .clrOnSyncEn(clrOnSyncEn), .loadOnSyncEn(loadOnSyncEn),
    .loadLsbFiltEn(loadLsbFiltEn), .syncNoData(syncNoData),
    .syncWithData(syncWithData), .syncLsb(syncData[0]), .strb(strb)
  );

  ttag_dp #(.TAG_W(TAG_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .syncData(syncData),
    .rollIrqEn(rollIrqEn), .timeTag(timeTag), .rollIrq(rollIrq)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (timeTag == '0 && !rollIrq) || rst_n); // R1
endmodule

// File: tb/ttag_counter_tb_top.sv
module ttag_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        usTick = 1'b0;
  logic [2:0]  resSel = 3'd0;
  logic        rollIrqEn = 1'b0;
  logic        clrOnSyncEn = 1'b0;
  logic        loadOnSyncEn = 1'b0;
  logic        loadLsbFiltEn = 1'b0;
  logic        syncNoData = 1'b0;
  logic        syncWithData = 1'b0;
  logic [15:0] syncData = 16'd0;
  logic [15:0] timeTag;
  logic        rollIrq;

  int total = 0;
  int bad = 0;
  string curReq = "R1";
  bit tickEvery = 1'b1;
  bit tickRun = 1'b0;
  int tickDiv = 0;

  int mCount = 0;
  int mPhase = 0;
  bit mIrq = 1'b0;
  int mSelPrev = 0;

  always #10 clk = ~clk;

  ttag_counter dut_i (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .resSel(resSel),
    .rollIrqEn(rollIrqEn), .clrOnSyncEn(clrOnSyncEn),
    .loadOnSyncEn(loadOnSyncEn), .loadLsbFiltEn(loadLsbFiltEn),
    .syncNoData(syncNoData), .syncWithData(syncWithData),
    .syncData(syncData), .timeTag(timeTag), .rollIrq(rollIrq)
  );

  // reference model: updates on the edge from the inputs presented there
  always @(posedge clk) begin
    if (!rst_n) begin
      mCount = 0; mPhase = 0; mIrq = 1'b0; mSelPrev = 0;
    end else begin
      int sel, per;
      bit doClr, doLoad;
      sel = (resSel > 3'd5) ? 5 : int'(resSel);
      per = 2 << sel;
      doClr = syncNoData && clrOnSyncEn;
      doLoad = !doClr && syncWithData && loadOnSyncEn && !(loadLsbFiltEn && syncData[0]);
      mIrq = 1'b0;
      if (doClr) begin mCount = 0; mPhase = 0; end
      else if (doLoad) begin mCount = int'(syncData); mPhase = 0; end
      else if (int'(resSel) != mSelPrev) mPhase = 0;
      else if (usTick) begin
        mPhase++;
        if (mPhase == per) begin
          mPhase = 0;
          if (mCount == 65535) begin mCount = 0; mIrq = rollIrqEn; end
          else mCount++;
        end
      end
      mSelPrev = int'(resSel);
    end
  end

  // compare every cycle, one cycle after the stimulus edge
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (timeTag !== 16'(mCount) || rollIrq !== mIrq) begin
        bad++;
        $display("FAIL %s: timeTag=%h rollIrq=%b expected timeTag=%h rollIrq=%b",
                 curReq, timeTag, rollIrq, 16'(mCount), mIrq);
      end
    end
  end

  // timebase strobe generator, driven on falling edges
  always @(negedge clk) begin
    if (!tickRun) usTick <= 1'b0;
    else if (tickEvery) usTick <= 1'b1;
    else begin
      tickDiv <= (tickDiv == 2) ? 0 : tickDiv + 1;
      usTick <= (tickDiv == 2);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadWord(input logic [15:0] w);
    @(negedge clk); syncData = w; syncWithData = 1'b1;
    @(negedge clk); syncWithData = 1'b0;
  endtask

  task automatic clrPulse();
    @(negedge clk); syncNoData = 1'b1;
    @(negedge clk); syncNoData = 1'b0;
  endtask

  initial begin
    #3000000;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    total++;
    if (timeTag !== 16'd0 || rollIrq !== 1'b0) begin
      bad++;
      $display("FAIL R1: timeTag=%h rollIrq=%b expected 0000 0", timeTag, rollIrq);
    end
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    // R2 every code, dense and sparse strobes
    curReq = "R2";
    tickRun = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); resSel = 3'(k);
      cyc(260);
    end
    tickEvery = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); resSel = 3'(k);
      cyc(150);
    end
    tickEvery = 1'b1;
    // R3 clamped codes
    curReq = "R3";
    @(negedge clk); resSel = 3'd6; cyc(200);
    @(negedge clk); resSel = 3'd7; cyc(200);
    // R4 wrap with interrupt
    curReq = "R4";
    @(negedge clk); resSel = 3'd0; loadOnSyncEn = 1'b1; rollIrqEn = 1'b1;
    loadWord(16'hFFF8);
    cyc(40);
    // R5 wrap without interrupt
    curReq = "R5";
    @(negedge clk); rollIrqEn = 1'b0;
    loadWord(16'hFFFA);
    cyc(30);
    // R6 clear enabled then disabled
    curReq = "R6";
    @(negedge clk); clrOnSyncEn = 1'b1; clrPulse(); cyc(9);
    @(negedge clk); clrOnSyncEn = 1'b0; clrPulse(); cyc(5);
    // R7 load enabled then disabled
    curReq = "R7";
    loadWord(16'h1234); cyc(7);
    @(negedge clk); loadOnSyncEn = 1'b0; loadWord(16'hABCD); cyc(5);
    // R8 lsb filter
    curReq = "R8";
    @(negedge clk); loadOnSyncEn = 1'b1; loadLsbFiltEn = 1'b1;
    loadWord(16'h5555); cyc(4);
    loadWord(16'h5554); cyc(4);
    @(negedge clk); loadLsbFiltEn = 1'b0;
    // R9 overrides at a due increment, clear wins over load
    curReq = "R9";
    @(negedge clk); resSel = 3'd1; clrOnSyncEn = 1'b1; cyc(3);
    for (int p = 0; p < 5; p++) begin
      cyc(p);
      loadWord(16'h0100 + 16'(p * 2)); cyc(2);
      clrPulse(); cyc(1);
    end
    @(negedge clk); syncData = 16'h7770; syncNoData = 1'b1; syncWithData = 1'b1;
    @(negedge clk); syncNoData = 1'b0; syncWithData = 1'b0;
    cyc(10);
    // R10 select change mid-interval
    curReq = "R10";
    @(negedge clk); resSel = 3'd2; cyc(5);
    @(negedge clk); resSel = 3'd3; cyc(11);
    @(negedge clk); resSel = 3'd0; cyc(1);
    @(negedge clk); resSel = 3'd1; cyc(20);
    tickRun = 1'b0;
    cyc(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule